// File: doc/BRIEF.md
# Double-Late-Write Burst SRAM Core

This block is a synchronous single-port static RAM with byte lanes. Its data bus has a separate input and output, plus a drive enable that an outer pad ring uses to tri-state the bus. All controls are sampled on the rising clock edge. A read presents its data from an output register two edges after the command. A write takes its data two edges after its command. Because of that lag, reads and writes can alternate every cycle and the shared bus never needs an idle turnaround cycle.

Each command opens a burst. While the advance input is high, the burst steps through four words in linear order. Only the two low address bits advance, and they wrap. Two bank enables have a polarity set by static strap inputs, so four identical cores can share one address bus and be told apart by two address lines. The core also drives an enable for the echo clock. That enable drops only when the bank itself is not selected. Writes that are still waiting for their data are held in a short pipeline. A read of a word whose data arrives on the same edge returns the new bytes.

The control state machine has four states:
- `ST_DESEL`: the chip is deselected by the primary enable.
- `ST_BANK_DESEL`: the bank enables do not match their straps.
- `ST_READ`: a read burst is in progress.
- `ST_WRITE`: a write burst is in progress.

Its transitions are:
- BEGIN (advance low): the state is chosen from the enables and the write input. A bank mismatch leads to `ST_BANK_DESEL`. Otherwise, a high primary enable leads to `ST_DESEL`. Otherwise, the write input picks `ST_READ` or `ST_WRITE`.
- CONTINUE (advance high): the state is held, and the burst address steps.

Top module: `dlw_sram_core`

## Requirements
- R1: On a synchronous reset, the core enters `ST_DESEL`. The data output register is cleared, so `dq_out` reads 0 and `dq_oe` reads 0. `cq_oe` reads 1. Any pending write is dropped. A read in progress when reset is taken never appears.
- R2: A read that begins at edge n (advance low, `e1_n` low, bank enable true, `we_n` high) sets `dq_oe` and places the addressed word on `dq_out` from edge n+1.
- R3: A write beat sampled at edge n takes its data from `dq_in` at edge n+2. Byte lane k is `dq_in[9k+8:9k]` under the default lane width, and it is written only if `bw_n[k]` is low.
- R4: The bank enable is true only when `e2` equals `ep2` and `e3` equals `ep3`. A beginning cycle with the bank enable false is a bank deselect: nothing is accessed, and `cq_oe` and `dq_oe` are 0 from the next edge after it.
- R5: A beginning cycle with the bank enable true and `e1_n` high is a deselect. Nothing is accessed, `dq_oe` is 0 and `cq_oe` stays 1.
- R6: With advance high during a read or write burst, the next beat uses the previous beat address plus one in the two low bits, modulo 4. The upper bits are unchanged, so a burst from 5 visits 5, 6, 7, 4.
- R7: A write beat with every `bw_n` bit high, whether it begins a burst or continues one, changes no stored byte. The `dq_in` value sampled for it is ignored.
- R8: `dq_oe` is 0 in every output slot that belongs to a write, deselect or bank-deselect beat.
- R9: A continue cycle that follows a deselect or bank deselect stays in that state, whatever the enables and write input do.
- R10: A read issued one cycle after a write to the same address returns the bytes written by that write, merged over the old word.
- R11: Writes and reads may alternate on consecutive cycles with no idle cycle, and each returns or stores the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | External start address of a burst |
| e1_n | input | 1 | Primary chip enable, active low |
| e2 | input | 1 | Bank enable A, polarity set by `ep2` |
| e3 | input | 1 | Bank enable B, polarity set by `ep3` |
| ep2 | input | 1 | Static strap: level of `e2` that selects |
| ep3 | input | 1 | Static strap: level of `e3` that selects |
| adv | input | 1 | High continues the burst, low begins a new cycle |
| we_n | input | 1 | Low selects write, high selects read |
| bw_n | input | LANES | Per-lane write enables, active low |
| dq_in | input | LANES*LANE_W | Write data, sampled two edges after its command |
| dq_out | output | LANES*LANE_W | Read data from the output register |
| dq_oe | output | 1 | Data bus drive enable |
| cq_oe | output | 1 | Echo clock drive enable |

## Verification
A wrong state register shows up at the ports one edge after the bad transition. `dq_oe` or `cq_oe` then takes the value of the wrong slot type, so a stuck or wrongly decoded state is visible within two cycles. A burst counter that carries into the upper bits, or that fails to wrap, returns the wrong word on the fourth beat of a burst. A write pipeline that is one stage short or long stores the neighbouring beat's data, and the next read-back of that address exposes it. A missing forward path gives stale bytes on a read issued right after a write.

// File: rtl/dlw_pkg.sv
`timescale 1ns/1ps
package dlw_pkg;

    // Kind of cycle the core is in; a CONTINUE keeps the current kind.
    typedef enum logic [1:0] {
        ST_DESEL      = 2'd0,
        ST_BANK_DESEL = 2'd1,
        ST_READ       = 2'd2,
        ST_WRITE      = 2'd3
    } dlw_state_e;

endpackage

// File: rtl/dlw_ctrl.sv
`timescale 1ns/1ps
module dlw_ctrl
    import dlw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic e1_n,
    input  logic bank_en,
    input  logic we_n,
    output logic beat_rd,
    output logic beat_wr,
    output logic bank_off,
    output logic load,
    output logic step
);

    dlw_state_e state_q;
    dlw_state_e cmd;
    dlw_state_e op;

    // BEGIN decode: bank mismatch has priority over the primary enable.
    always_comb begin
        if (!bank_en)    cmd = ST_BANK_DESEL;
        else if (e1_n)   cmd = ST_DESEL;
        else if (we_n)   cmd = ST_READ;
        else             cmd = ST_WRITE;
    end

    // Transition: BEGIN takes the decoded command, CONTINUE holds the state.
    always_comb begin
        unique case (adv)
            1'b0: op = cmd;
            1'b1: op = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DESEL;
        else     state_q <= op;
    end

    always_comb begin
        beat_rd  = 1'b0;
        beat_wr  = 1'b0;
        bank_off = 1'b0;
        unique case (op)
            ST_DESEL:      ;
            ST_BANK_DESEL: bank_off = 1'b1;
            ST_READ:       beat_rd  = 1'b1;
            ST_WRITE:      beat_wr  = 1'b1;
        endcase
        load = !adv && (beat_rd || beat_wr);
        step =  adv && (beat_rd || beat_wr);
    end

    AST_CONT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        adv |=> state_q == $past(state_q)); // R9
    AST_BANK_DECODE: assert property (@(posedge clk) disable iff (rst)
        (!adv && !bank_en) |=> state_q == ST_BANK_DESEL); // R4
    AST_E1_DESEL: assert property (@(posedge clk) disable iff (rst)
        (!adv && bank_en && e1_n) |=> state_q == ST_DESEL); // R5
    AST_READ_START: assert property (@(posedge clk) disable iff (rst)
        (!adv && bank_en && !e1_n && we_n) |=> state_q == ST_READ); // R2

endmodule

// File: rtl/dlw_burst.sv
`timescale 1ns/1ps
module dlw_burst #(
    parameter int ADDR_W    = 6,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] beat_addr
);

    localparam int LOW_W = $clog2(BURST_LEN);

    logic [ADDR_W-1:0] cur_q;

    // Linear order: only the low field counts, and it wraps.
    always_comb begin
        if (load) beat_addr = ext_addr;
        else      beat_addr = {cur_q[ADDR_W-1:LOW_W], cur_q[LOW_W-1:0] + LOW_W'(1)};
    end

    always_ff @(posedge clk) begin
        if (rst)               cur_q <= '0;
        else if (load || step) cur_q <= beat_addr;
    end

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (rst)
        step |-> beat_addr[LOW_W-1:0] == LOW_W'($past(beat_addr[LOW_W-1:0]) + LOW_W'(1))); // R6
    AST_BURST_UPPER: assert property (@(posedge clk) disable iff (rst)
        step |-> beat_addr[ADDR_W-1:LOW_W] == $past(beat_addr[ADDR_W-1:LOW_W])); // R6

endmodule

// File: rtl/dlw_datapath.sv
`timescale 1ns/1ps
module dlw_datapath #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     beat_rd,
    input  logic                     beat_wr,
    input  logic                     bank_off,
    input  logic [ADDR_W-1:0]        beat_addr,
    input  logic [LANES-1:0]         bw_n,
    input  logic [LANES*LANE_W-1:0]  dq_in,
    output logic [LANES*LANE_W-1:0]  dq_out,
    output logic                     dq_oe,
    output logic                     cq_oe
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WR_LAT = 2;
    localparam int TAIL   = WR_LAT - 1;

    // Pending writes: stage 0 holds the newest beat, TAIL commits.
    logic              wv_q [WR_LAT];
    logic [ADDR_W-1:0] wa_q [WR_LAT];
    logic [LANES-1:0]  wm_q [WR_LAT];

    logic              rd_v_q;
    logic [ADDR_W-1:0] rd_a_q;
    logic              cq_p_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < WR_LAT; k++) wv_q[k] <= 1'b0;
        end else begin
            wv_q[0] <= beat_wr && (bw_n != '1);
            for (int k = 1; k < WR_LAT; k++) wv_q[k] <= wv_q[k-1];
        end
        wa_q[0] <= beat_addr;
        wm_q[0] <= ~bw_n;
        for (int k = 1; k < WR_LAT; k++) begin
            wa_q[k] <= wa_q[k-1];
            wm_q[k] <= wm_q[k-1];
        end
    end

    // Read access stage and output enable pipeline.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_v_q <= 1'b0;
            cq_p_q <= 1'b1;
            dq_oe  <= 1'b0;
            cq_oe  <= 1'b1;
        end else begin
            rd_v_q <= beat_rd;
            cq_p_q <= !bank_off;
            dq_oe  <= rd_v_q;
            cq_oe  <= cq_p_q;
        end
        rd_a_q <= beat_addr;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] din_l;
        logic [LANE_W-1:0] rd_l;
        logic [LANE_W-1:0] q_l;
        logic              commit;
        logic              hit;

        assign din_l  = dq_in[l*LANE_W +: LANE_W];
        assign commit = wv_q[TAIL] && wm_q[TAIL][l];
        assign hit    = commit && (wa_q[TAIL] == rd_a_q);

        // Forward the byte that lands on this same edge.
        always_comb rd_l = hit ? din_l : mem[rd_a_q];

        always_ff @(posedge clk) begin
            if (commit) mem[wa_q[TAIL]] <= din_l;
        end

        always_ff @(posedge clk) begin
            if (rst)         q_l <= '0;
            else if (rd_v_q) q_l <= rd_l;
        end

        assign dq_out[l*LANE_W +: LANE_W] = q_l;
    end

    AST_OE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        beat_rd |=> ##1 dq_oe); // R2
    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> $past(beat_rd, 2)); // R8
    AST_CQ_OFF_BANK: assert property (@(posedge clk) disable iff (rst)
        !cq_oe |-> $past(bank_off, 2)); // R4
    AST_CQ_KEPT: assert property (@(posedge clk) disable iff (rst)
        !bank_off |=> ##1 cq_oe); // R5
    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (beat_wr && (&bw_n)) |=> ##1 !wv_q[TAIL]); // R7
    AST_WRITE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (beat_wr && !(&bw_n)) |=> ##1 wv_q[TAIL]); // R3

endmodule

// File: rtl/dlw_sram_core.sv
`timescale 1ns/1ps
module dlw_sram_core #(
    parameter int ADDR_W    = 6,
    parameter int LANES     = 4,
    parameter int LANE_W    = 9,
    parameter int BURST_LEN = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     e1_n,
    input  logic                     e2,
    input  logic                     e3,
    input  logic                     ep2,
    input  logic                     ep3,
    input  logic                     adv,
    input  logic                     we_n,
    input  logic [LANES-1:0]         bw_n,
    input  logic [LANES*LANE_W-1:0]  dq_in,
    output logic [LANES*LANE_W-1:0]  dq_out,
    output logic                     dq_oe,
    output logic                     cq_oe
);

    logic              bank_en;
    logic              beat_rd;
    logic              beat_wr;
    logic              bank_off;
    logic              load;
    logic              step;
    logic [ADDR_W-1:0] beat_addr;

    // Straps give each bank enable its active level.
    assign bank_en = (e2 == ep2) && (e3 == ep3);

    dlw_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .e1_n     (e1_n),
        .bank_en  (bank_en),
        .we_n     (we_n),
        .beat_rd  (beat_rd),
        .beat_wr  (beat_wr),
        .bank_off (bank_off),
        .load     (load),
        .step     (step)
    );

    dlw_burst #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .ext_addr  (addr),
        .beat_addr (beat_addr)
    );

    dlw_datapath #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .beat_rd   (beat_rd),
        .beat_wr   (beat_wr),
        .bank_off  (bank_off),
        .beat_addr (beat_addr),
        .bw_n      (bw_n),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .cq_oe     (cq_oe)
    );

endmodule

// File: tb/dlw_sram_core_test.sv
`timescale 1ns/1ps
module dlw_sram_core_test;

    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    localparam logic [35:0] D0 = 36'h123456789;
    localparam logic [35:0] D1 = 36'hA5A5A5A5A;
    localparam logic [35:0] D2 = 36'h0F0F0F0F0;
    localparam logic [35:0] D3 = 36'h876543210;
    localparam logic [35:0] D4 = 36'h5C3A1E7D2;
    localparam logic [35:0] D5 = 36'h3C3C3C3C3;
    localparam logic [35:0] D6 = 36'h7E1D2B4A9;
    localparam logic [35:0] M4 = 36'h1234566AB; // D0 with lane 0 = 0x0AB
    localparam logic [35:0] ONES = 36'hFFFFFFFFF;

    typedef struct packed {
        logic        adv;
        logic        e1n;
        logic        e2;
        logic        wen;
        logic [3:0]  bwn;
        logic [5:0]  addr;
        logic [35:0] din;
        logic        eoe;
        logic        ecq;
        logic [35:0] edo;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 23;
    // Expected columns are the outputs right after the edge that samples the row.
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,4'b0000,6'h04,36'h0, 1'b0,1'b1,36'h0, 4'd3},  // R3 write burst from 4
        '{1'b1,1'b0,1'b1,1'b0,4'b0000,6'h00,36'h0, 1'b0,1'b1,36'h0, 4'd6},  // R6 continue to 5
        '{1'b1,1'b0,1'b1,1'b0,4'b0000,6'h00,D0,    1'b0,1'b1,36'h0, 4'd3},  // R3 data for 4
        '{1'b1,1'b0,1'b1,1'b0,4'b0000,6'h00,D1,    1'b0,1'b1,36'h0, 4'd8},  // R8 data for 5
        '{1'b0,1'b0,1'b1,1'b1,4'b1111,6'h05,D2,    1'b0,1'b1,36'h0, 4'd11}, // R11 read right after writes
        '{1'b1,1'b0,1'b1,1'b1,4'b1111,6'h00,D3,    1'b1,1'b1,D1,    4'd2},  // R2 word 5
        '{1'b1,1'b0,1'b1,1'b1,4'b1111,6'h00,36'h0, 1'b1,1'b1,D2,    4'd6},  // R6 word 6
        '{1'b1,1'b0,1'b1,1'b1,4'b1111,6'h00,36'h0, 1'b1,1'b1,D3,    4'd6},  // R6 word 7
        '{1'b0,1'b0,1'b1,1'b0,4'b1110,6'h04,36'h0, 1'b1,1'b1,D0,    4'd6},  // R6 wrap to 4
        '{1'b0,1'b0,1'b1,1'b1,4'b1111,6'h04,36'h0, 1'b0,1'b1,36'h0, 4'd8},  // R8 write slot
        '{1'b0,1'b1,1'b1,1'b1,4'b1111,6'h00,36'hFFFFFFEAB,1'b1,1'b1,M4, 4'd10}, // R10 forward
        '{1'b0,1'b0,1'b0,1'b1,4'b1111,6'h00,36'h0, 1'b0,1'b1,36'h0, 4'd5},  // R5 deselect slot
        '{1'b1,1'b0,1'b1,1'b1,4'b1111,6'h00,36'h0, 1'b0,1'b0,36'h0, 4'd4},  // R4 bank off
        '{1'b1,1'b0,1'b1,1'b1,4'b1111,6'h00,36'h0, 1'b0,1'b0,36'h0, 4'd9},  // R9 continue stays
        '{1'b0,1'b0,1'b1,1'b1,4'b1111,6'h04,36'h0, 1'b0,1'b0,36'h0, 4'd9},  // R9 still bank off
        '{1'b0,1'b0,1'b1,1'b0,4'b1111,6'h04,36'h0, 1'b1,1'b1,M4,    4'd3},  // R3 lane 0 stored
        '{1'b0,1'b0,1'b1,1'b0,4'b0000,6'h10,36'h0, 1'b0,1'b1,36'h0, 4'd8},  // R8 abort slot
        '{1'b0,1'b0,1'b1,1'b1,4'b1111,6'h04,ONES,  1'b0,1'b1,36'h0, 4'd11}, // R11 alternate
        '{1'b0,1'b1,1'b1,1'b1,4'b1111,6'h00,D4,    1'b1,1'b1,M4,    4'd7},  // R7 abort kept word
        '{1'b0,1'b0,1'b1,1'b1,4'b1111,6'h10,36'h0, 1'b0,1'b1,36'h0, 4'd5},  // R5 deselect slot
        '{1'b0,1'b1,1'b1,1'b1,4'b1111,6'h00,36'h0, 1'b1,1'b1,D4,    4'd11}, // R11 word 0x10
        '{1'b1,1'b0,1'b1,1'b1,4'b1111,6'h00,36'h0, 1'b0,1'b1,36'h0, 4'd5},  // R5 deselect slot
        '{1'b0,1'b1,1'b1,1'b1,4'b1111,6'h00,36'h0, 1'b0,1'b1,36'h0, 4'd9}   // R9 continue stayed
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          e1_n = 1'b1;
    logic          e2 = 1'b1;
    logic          e3 = 1'b0;
    logic          ep2 = 1'b1;
    logic          ep3 = 1'b0;
    logic          adv = 1'b0;
    logic          we_n = 1'b1;
    logic [LN-1:0] bw_n = '1;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          cq_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dlw_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .BURST_LEN(4)) uut (
        .clk(clk), .rst(rst), .addr(addr), .e1_n(e1_n), .e2(e2), .e3(e3),
        .ep2(ep2), .ep3(ep3), .adv(adv), .we_n(we_n), .bw_n(bw_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .cq_oe(cq_oe)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, return 1 ns after the next rising edge.
    task automatic cyc(input logic a, input logic e1, input logic e2v, input logic w,
                       input logic [3:0] b, input logic [5:0] ad, input logic [35:0] d);
        @(negedge clk);
        adv = a; e1_n = e1; e2 = e2v; we_n = w; bw_n = b; addr = ad; dq_in = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, 6'h00, 36'h0);
        chk("R1 reset dq_oe", {35'b0, dq_oe}, 36'h0);
        chk("R1 reset cq_oe", {35'b0, cq_oe}, 36'h1);
        chk("R1 reset dq_out", dq_out, 36'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].adv, VEC[i].e1n, VEC[i].e2, VEC[i].wen, VEC[i].bwn, VEC[i].addr, VEC[i].din);
            chk($sformatf("R%0d row %0d dq_oe", VEC[i].rq, i), {35'b0, dq_oe}, {35'b0, VEC[i].eoe});
            chk($sformatf("R%0d row %0d cq_oe", VEC[i].rq, i), {35'b0, cq_oe}, {35'b0, VEC[i].ecq});
            if (VEC[i].eoe)
                chk($sformatf("R%0d row %0d dq_out", VEC[i].rq, i), dq_out, VEC[i].edo);
        end

        // R7: a continue beat with all byte enables high stores nothing.
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 6'h21, 36'h0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, 6'h00, 36'h0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, 6'h00, D5);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 6'h20, 36'h0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 4'b1111, 6'h00, 36'h0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'b1111, 6'h21, D6);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, 6'h00, ONES);
        chk("R7 non-write continue beat", dq_out, D5);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'b1111, 6'h20, 36'h0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, 6'h00, 36'h0);
        chk("R3 burst head stored", dq_out, D6);

        // R1: reset taken while a read is in flight.
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'b1111, 6'h20, 36'h0);
        rst = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, 6'h00, 36'h0);
        chk("R1 mid-read reset dq_oe", {35'b0, dq_oe}, 36'h0);
        chk("R1 mid-read reset dq_out", dq_out, 36'h0);
        chk("R1 mid-read reset cq_oe", {35'b0, cq_oe}, 36'h1);
        ep2 = 1'b0; ep3 = 1'b1; e3 = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h00, 36'h0);
        rst = 1'b0;

        // R4: inverted strap polarity selects with e2 low and e3 high.
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'b1111, 6'h20, 36'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h00, 36'h0);
        chk("R4 inverted straps read oe", {35'b0, dq_oe}, 36'h1);
        chk("R4 inverted straps read data", dq_out, D6);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'b1111, 6'h20, 36'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h00, 36'h0);
        chk("R4 strap mismatch cq_oe", {35'b0, cq_oe}, 36'h0);
        chk("R4 strap mismatch dq_oe", {35'b0, dq_oe}, 36'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h00, 36'h0);
        chk("R5 e1 deselect keeps cq_oe", {35'b0, cq_oe}, 36'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule